// File: doc/BRIEF.md
# Physical Address Router with Hole Reclaim

This block sits between a processor's physical address output and the system fabric. Each accepted request is classified into exactly one destination: system DRAM, one of the fixed platform windows below 4 GB (configuration space, the I/O interrupt controller, the timer, the local interrupt controller and boot flash), a relocatable 32-bit MMIO window, a relocatable 64-bit MMIO window, or no destination at all. For DRAM hits it also produces the DRAM-side address, folding the memory shadowed by the MMIO hole back into a window that opens at 4 GB.

Boundary values (top of low DRAM, installed DRAM size, MMIO window bases and sizes) are written once after reset and then frozen by a lock write. At lock time the block checks window legality and overlaps and latches two sticky error flags. Until the lock is written the request port is not ready; afterwards every request is decoded with a fixed one-cycle latency.

Top module: `pa_route_dec`

## Requirements
- R1: An address below min(top-of-low-DRAM, installed size) and in no fixed or MMIO window returns target 1 (DRAM) with the translated address equal to the input.
- R2: An address from top-of-low-DRAM up to 0xFFFF_FFFF never returns target 1, whatever DRAM size is installed.
- R3: An address A with 4 GB <= A < 4 GB + (installed size − top-of-low-DRAM) returns target 1 with translated address A − 4 GB + top-of-low-DRAM; this covers both the reclaimed portion and the DRAM that continues linearly above it.
- R4: Fixed windows return target 2 with a platform code: 0 for 0xE000_0000 (256 MB), 1 for 0xFEC0_0000 (1 MB), 2 for 0xFED0_0000 (64 KB), 3 for 0xFEE0_0000 (64 KB), 4 for 0xFF00_0000 (16 MB). They win over every other window.
- R5: An enabled 32-bit MMIO window returns target 3 with the address passed through; a window reaching above 0xFFFF_FFFF is illegal.
- R6: An enabled 64-bit MMIO window returns target 4 with the address passed through; it may sit anywhere in the 46-bit space.
- R7: A window with nonzero size that is not a power of two, is not aligned to its size, or breaks its placement limit is disabled and sets the sticky configuration error flag at lock; size zero simply disables it.
- R8: Any pair of enabled regions (low DRAM, reclaim range, fixed windows, MMIO windows) sharing an address sets the sticky overlap flag at lock.
- R9: An address matching no region returns target 0, platform code 0, translated address 0 and the decode error bit set.
- R10: Ready is low from reset until the lock write; the response (valid, target, platform code, address, error) appears exactly one cycle after a request accepted with valid and ready high, and valid is low otherwise.
- R11: Configuration writes (select 0 top-of-low-DRAM, 1 installed size, 2/3 32-bit window base/size, 4/5 64-bit window base/size, 6 lock on data bit 0) after the lock have no effect until reset.
- R12: Priority is fixed windows, then 32-bit MMIO, then 64-bit MMIO, then DRAM and reclaim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | AW | Configuration write data |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | AW | Physical address of request |
| req_ready_o | output | 1 | Request ready (high once locked) |
| rsp_valid_o | output | 1 | Response valid |
| rsp_tgt_o | output | 3 | Target code |
| rsp_plat_o | output | 3 | Platform window code |
| rsp_addr_o | output | AW | Translated or passed-through address |
| rsp_err_o | output | 1 | Decode error (no target) |
| cfg_err_o | output | 1 | Sticky illegal-window flag |
| ovl_err_o | output | 1 | Sticky overlap flag |

## Verification
Assertions watch every cycle that a response follows an accepted request by exactly one cycle, that nothing in the hole ever decodes to DRAM, that DRAM-side addresses stay below the installed size, and that locked configuration, ready and both error flags never change again. The exact translated values, the platform codes, priority between overlapping windows and the legality and overlap rules can only be shown by the bench's scenarios, which load three different configurations and probe the edges of every region.

// File: rtl/pa_route_pkg.sv
package pa_route_pkg;
  localparam int unsigned PA_W = 46;
  localparam int unsigned NFIX = 5;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_DRAM   = 3'd1,
    TGT_PLAT   = 3'd2,
    TGT_MMIO32 = 3'd3,
    TGT_MMIO64 = 3'd4
  } tgt_e;

  // fixed platform windows, index is the platform code
  localparam logic [31:0] FIX_BASE [NFIX] =
    '{32'hE000_0000, 32'hFEC0_0000, 32'hFED0_0000, 32'hFEE0_0000, 32'hFF00_0000};
  localparam int unsigned FIX_LSZ [NFIX] = '{28, 20, 16, 16, 24};

  localparam logic [2:0] SEL_TOLM  = 3'd0;
  localparam logic [2:0] SEL_DRAM  = 3'd1;
  localparam logic [2:0] SEL_B32   = 3'd2;
  localparam logic [2:0] SEL_S32   = 3'd3;
  localparam logic [2:0] SEL_B64   = 3'd4;
  localparam logic [2:0] SEL_S64   = 3'd5;
  localparam logic [2:0] SEL_LOCK  = 3'd6;
endpackage

// File: rtl/pa_route_win_chk.sv
module pa_route_win_chk #(
  parameter int unsigned AW       = 46,
  parameter bit          BELOW_4G = 1'b1
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  output logic          en_o,
  output logic          bad_o
);
  logic [AW:0] end_x;
  logic        pow2, aligned, fits;

  assign end_x   = {1'b0, base_i} + {1'b0, size_i};
  assign pow2    = (size_i & (size_i - AW'(1))) == '0;
  assign aligned = (base_i & (size_i - AW'(1))) == '0;

  generate
    if (BELOW_4G) begin : g_low
      assign fits = end_x <= (AW+1)'(64'h1_0000_0000);
    end else begin : g_any
      assign fits = !end_x[AW];
    end
  endgenerate

  assign en_o  = (size_i != '0) && pow2 && aligned && fits;
  assign bad_o = (size_i != '0) && !(pow2 && aligned && fits);
endmodule

// File: rtl/pa_route_cfg.sv
module pa_route_cfg
  import pa_route_pkg::*;
#(
  parameter int unsigned AW = PA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] tolm_o,
  output logic [AW-1:0] dram_o,
  output logic [AW-1:0] b32_o,
  output logic [AW-1:0] s32_o,
  output logic [AW-1:0] b64_o,
  output logic [AW-1:0] s64_o,
  output logic          en32_o,
  output logic          en64_o,
  output logic          lock_o,
  output logic          cfg_err_o,
  output logic          ovl_err_o
);
  localparam logic [AW:0] FOUR_G = (AW+1)'(64'h1_0000_0000);

  logic [AW-1:0] tolm_q, dram_q, b32_q, s32_q, b64_q, s64_q;
  logic          lock_q, cerr_q, oerr_q;
  logic          bad32, bad64, any_ovl, lock_set;
  logic [AW:0]   lo_end, rc_end, e32, e64;
  logic [AW-1:0] hi_len;

  pa_route_win_chk #(.AW(AW), .BELOW_4G(1'b1)) u_chk32 (
    .base_i(b32_q), .size_i(s32_q), .en_o(en32_o), .bad_o(bad32));
  pa_route_win_chk #(.AW(AW), .BELOW_4G(1'b0)) u_chk64 (
    .base_i(b64_q), .size_i(s64_q), .en_o(en64_o), .bad_o(bad64));

  function automatic logic ovl(input logic [AW:0] alo, ahi, blo, bhi);
    return (alo < ahi) && (blo < bhi) && (alo < bhi) && (blo < ahi);
  endfunction

  always_comb begin
    logic [AW:0] flo, fhi;
    hi_len = (dram_q > tolm_q) ? dram_q - tolm_q : '0;
    lo_end = (dram_q < tolm_q) ? {1'b0, dram_q} : {1'b0, tolm_q};
    rc_end = FOUR_G + {1'b0, hi_len};
    e32    = {1'b0, b32_q} + {1'b0, s32_q};
    e64    = {1'b0, b64_q} + {1'b0, s64_q};
    any_ovl = 1'b0;
    for (int i = 0; i < NFIX; i++) begin
      flo = (AW+1)'(FIX_BASE[i]);
      fhi = flo + ((AW+1)'(1) << FIX_LSZ[i]);
      any_ovl |= ovl(flo, fhi, '0, lo_end);
      any_ovl |= en32_o && ovl(flo, fhi, {1'b0, b32_q}, e32);
      any_ovl |= en64_o && ovl(flo, fhi, {1'b0, b64_q}, e64);
    end
    any_ovl |= en32_o && ovl({1'b0, b32_q}, e32, '0, lo_end);
    any_ovl |= en64_o && ovl({1'b0, b64_q}, e64, '0, lo_end);
    any_ovl |= en64_o && ovl({1'b0, b64_q}, e64, FOUR_G, rc_end);
    any_ovl |= en32_o && en64_o && ovl({1'b0, b32_q}, e32, {1'b0, b64_q}, e64);
  end

  assign lock_set = we_i && !lock_q && (sel_i == SEL_LOCK) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tolm_q <= '0; dram_q <= '0; b32_q <= '0; s32_q <= '0;
      b64_q  <= '0; s64_q  <= '0;
      lock_q <= 1'b0; cerr_q <= 1'b0; oerr_q <= 1'b0;
    end else if (we_i && !lock_q) begin
      unique case (sel_i)
        SEL_TOLM: tolm_q <= wdata_i;
        SEL_DRAM: dram_q <= wdata_i;
        SEL_B32:  b32_q  <= wdata_i;
        SEL_S32:  s32_q  <= wdata_i;
        SEL_B64:  b64_q  <= wdata_i;
        SEL_S64:  s64_q  <= wdata_i;
        default: ;
      endcase
      if (lock_set) begin
        lock_q <= 1'b1;
        cerr_q <= bad32 || bad64;
        oerr_q <= any_ovl;
      end
    end
  end

  assign tolm_o = tolm_q; assign dram_o = dram_q;
  assign b32_o  = b32_q;  assign s32_o  = s32_q;
  assign b64_o  = b64_q;  assign s64_o  = s64_q;
  assign lock_o = lock_q; assign cfg_err_o = cerr_q; assign ovl_err_o = oerr_q;

  assert_cfg_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(tolm_q) && $stable(dram_q) && $stable(b32_q) &&
                $stable(s32_q) && $stable(b64_q) && $stable(s64_q) && lock_q));
  assert_cfg_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cerr_q |=> cerr_q);
  assert_ovl_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oerr_q |=> oerr_q);
endmodule

// File: rtl/pa_route_match.sv
module pa_route_match
  import pa_route_pkg::*;
#(
  parameter int unsigned AW = PA_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] tolm_i,
  input  logic [AW-1:0] dram_i,
  input  logic [AW-1:0] b32_i,
  input  logic [AW-1:0] s32_i,
  input  logic [AW-1:0] b64_i,
  input  logic [AW-1:0] s64_i,
  input  logic          en32_i,
  input  logic          en64_i,
  output tgt_e          tgt_o,
  output logic [2:0]    plat_o,
  output logic [AW-1:0] xlat_o
);
  localparam logic [AW:0] FOUR_G = (AW+1)'(64'h1_0000_0000);

  logic          fix_hit, hit32, hit64, lo_hit, rc_hit;
  logic [2:0]    fix_id;
  logic [AW-1:0] hi_len, lo_lim;
  logic [AW:0]   ax, rc_off;

  always_comb begin
    fix_hit = 1'b0;
    fix_id  = '0;
    for (int i = NFIX - 1; i >= 0; i--) begin
      if (((addr_i ^ AW'(FIX_BASE[i])) >> FIX_LSZ[i]) == '0) begin
        fix_hit = 1'b1;
        fix_id  = 3'(i);
      end
    end
  end

  assign hit32  = en32_i && (((addr_i ^ b32_i) & ~(s32_i - AW'(1))) == '0);
  assign hit64  = en64_i && (((addr_i ^ b64_i) & ~(s64_i - AW'(1))) == '0);
  assign hi_len = (dram_i > tolm_i) ? dram_i - tolm_i : '0;
  assign lo_lim = (dram_i < tolm_i) ? dram_i : tolm_i;
  assign ax     = {1'b0, addr_i};
  assign lo_hit = addr_i < lo_lim;
  assign rc_hit = (ax >= FOUR_G) && (ax < FOUR_G + {1'b0, hi_len});
  assign rc_off = ax - FOUR_G + {1'b0, tolm_i};

  always_comb begin
    tgt_o  = TGT_NONE;
    plat_o = '0;
    xlat_o = '0;
    if (fix_hit) begin
      tgt_o  = TGT_PLAT;
      plat_o = fix_id;
      xlat_o = addr_i;
    end else if (hit32) begin
      tgt_o  = TGT_MMIO32;
      xlat_o = addr_i;
    end else if (hit64) begin
      tgt_o  = TGT_MMIO64;
      xlat_o = addr_i;
    end else if (lo_hit) begin
      tgt_o  = TGT_DRAM;
      xlat_o = addr_i;
    end else if (rc_hit) begin
      tgt_o  = TGT_DRAM;
      xlat_o = rc_off[AW-1:0];
    end
  end
endmodule

// File: rtl/pa_route_dec.sv
module pa_route_dec
  import pa_route_pkg::*;
#(
  parameter int unsigned AW = PA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic [2:0]    rsp_tgt_o,
  output logic [2:0]    rsp_plat_o,
  output logic [AW-1:0] rsp_addr_o,
  output logic          rsp_err_o,
  output logic          cfg_err_o,
  output logic          ovl_err_o
);
  logic [AW-1:0] tolm, dram, b32, s32, b64, s64, xlat;
  logic          en32, en64, lock, acc;
  tgt_e          tgt;
  logic [2:0]    plat;

  pa_route_cfg #(.AW(AW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .tolm_o(tolm), .dram_o(dram), .b32_o(b32), .s32_o(s32),
    .b64_o(b64), .s64_o(s64), .en32_o(en32), .en64_o(en64),
    .lock_o(lock), .cfg_err_o, .ovl_err_o);

  pa_route_match #(.AW(AW)) u_match (
    .addr_i(req_addr_i), .tolm_i(tolm), .dram_i(dram),
    .b32_i(b32), .s32_i(s32), .b64_i(b64), .s64_i(s64),
    .en32_i(en32), .en64_i(en64),
    .tgt_o(tgt), .plat_o(plat), .xlat_o(xlat));

  assign req_ready_o = lock;
  assign acc         = req_valid_i && lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_tgt_o   <= '0;
      rsp_plat_o  <= '0;
      rsp_addr_o  <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= acc;
      if (acc) begin
        rsp_tgt_o  <= tgt;
        rsp_plat_o <= plat;
        rsp_addr_o <= xlat;
        rsp_err_o  <= (tgt == TGT_NONE);
      end
    end
  end

  assert_rsp_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);
  assert_no_rsp_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o);
  assert_ready_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> req_ready_o);
  assert_hole_not_dram_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && ($past(req_addr_i) >= tolm) &&
     ($past(req_addr_i) <= AW'(64'hFFFF_FFFF))) |-> (rsp_tgt_o != TGT_DRAM));
  assert_dram_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_tgt_o == TGT_DRAM) |-> (rsp_addr_o < dram));
  assert_err_no_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_tgt_o == TGT_NONE && rsp_addr_o == '0));
endmodule

// File: tb/pa_route_dec_tb.sv
module pa_route_dec_tb;
  localparam int AW = 46;
  localparam int NV = 21;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [2:0]    tgt;
    logic [2:0]    plat;
    logic [AW-1:0] xl;
    logic [3:0]    req;
  } vec_t;

  // config A: low DRAM to 3 GB, 8 GB installed, 32-bit MMIO 0xD000_0000/256M, 64-bit 0x40_0000_0000/256M
  localparam vec_t VEC [NV] = '{
    '{46'h0000_0000,    3'd1, 3'd0, 46'h0000_0000,    4'd1},  // R1
    '{46'hBFFF_FFFF,    3'd1, 3'd0, 46'hBFFF_FFFF,    4'd1},  // R1
    '{46'hC000_0000,    3'd0, 3'd0, 46'h0,            4'd2},  // R2 hole
    '{46'hD000_0000,    3'd3, 3'd0, 46'hD000_0000,    4'd5},  // R5
    '{46'hDFFF_FFFF,    3'd3, 3'd0, 46'hDFFF_FFFF,    4'd5},  // R5
    '{46'hE000_0000,    3'd2, 3'd0, 46'hE000_0000,    4'd4},  // R4
    '{46'hFEC0_0000,    3'd2, 3'd1, 46'hFEC0_0000,    4'd4},  // R4
    '{46'hFED0_FFFF,    3'd2, 3'd2, 46'hFED0_FFFF,    4'd4},  // R4
    '{46'hFED1_0000,    3'd0, 3'd0, 46'h0,            4'd2},  // R2 gap
    '{46'hFEE0_0000,    3'd2, 3'd3, 46'hFEE0_0000,    4'd4},  // R4
    '{46'hFF00_0000,    3'd2, 3'd4, 46'hFF00_0000,    4'd4},  // R4
    '{46'hFFFF_FFFF,    3'd2, 3'd4, 46'hFFFF_FFFF,    4'd4},  // R4
    '{46'h1_0000_0000,  3'd1, 3'd0, 46'hC000_0000,    4'd3},  // R3 reclaim
    '{46'h1_3FFF_FFFF,  3'd1, 3'd0, 46'hFFFF_FFFF,    4'd3},  // R3
    '{46'h1_4000_0000,  3'd1, 3'd0, 46'h1_0000_0000,  4'd3},  // R3 linear
    '{46'h2_3FFF_FFFF,  3'd1, 3'd0, 46'h1_FFFF_FFFF,  4'd3},  // R3 top
    '{46'h2_4000_0000,  3'd0, 3'd0, 46'h0,            4'd9},  // R9
    '{46'h40_0000_0000, 3'd4, 3'd0, 46'h40_0000_0000, 4'd6},  // R6
    '{46'h40_0FFF_FFFF, 3'd4, 3'd0, 46'h40_0FFF_FFFF, 4'd6},  // R6
    '{46'h40_1000_0000, 3'd0, 3'd0, 46'h0,            4'd9},  // R9
    '{46'h3FFF_FFFF_FFFF, 3'd0, 3'd0, 46'h0,          4'd9}   // R9
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [2:0]    cfg_sel_i = '0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_ready_o, rsp_valid_o, rsp_err_o, cfg_err_o, ovl_err_o;
  logic [2:0]    rsp_tgt_o, rsp_plat_o;
  logic [AW-1:0] rsp_addr_o;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #10 clk_i = ~clk_i;

  pa_route_dec #(.AW(AW)) u_dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; cfg_we_i = 1'b0; req_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic load(input logic [AW-1:0] tolm, dram, b32, s32, b64, s64);
    wr(3'd0, tolm); wr(3'd1, dram); wr(3'd2, b32);
    wr(3'd3, s32);  wr(3'd4, b64);  wr(3'd5, s64);
  endtask

  task automatic probe(input string tag, input logic [AW-1:0] a, input logic [2:0] tgt,
                       input logic [2:0] plat, input logic [AW-1:0] xl);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({tag, " valid"}, 64'(rsp_valid_o), 64'd1);
    chk({tag, " tgt"},   64'(rsp_tgt_o), 64'(tgt));
    chk({tag, " plat"},  64'(rsp_plat_o), 64'(plat));
    chk({tag, " addr"},  64'(rsp_addr_o), 64'(xl));
    chk({tag, " err"},   64'(rsp_err_o), 64'(tgt == 3'd0));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // reset state, R10
    chk("R10 reset ready", 64'(req_ready_o), 64'd0);
    chk("R10 reset valid", 64'(rsp_valid_o), 64'd0);
    chk("R7 reset cfg_err", 64'(cfg_err_o), 64'd0);
    chk("R8 reset ovl_err", 64'(ovl_err_o), 64'd0);

    load(46'hC000_0000, 46'h2_0000_0000, 46'hD000_0000, 46'h1000_0000,
         46'h40_0000_0000, 46'h1000_0000);
    // request before lock is not accepted, R10
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = '0;
    chk("R10 not ready before lock", 64'(req_ready_o), 64'd0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R10 no response before lock", 64'(rsp_valid_o), 64'd0);
    wr(3'd6, 46'd1);
    chk("R10 ready after lock", 64'(req_ready_o), 64'd1);
    chk("R7 config A clean", 64'(cfg_err_o), 64'd0);
    chk("R8 config A clean", 64'(ovl_err_o), 64'd0);

    for (int i = 0; i < NV; i++) begin
      probe($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].addr, VEC[i].tgt,
            VEC[i].plat, VEC[i].xl);
    end

    // R10 valid drops one cycle after request ends
    @(negedge clk_i);
    chk("R10 idle valid low", 64'(rsp_valid_o), 64'd0);

    // R11 writes after lock ignored
    wr(3'd0, 46'h0);
    wr(3'd2, 46'h0);
    probe("R11 tolm kept", 46'h1000, 3'd1, 3'd0, 46'h1000);
    probe("R11 m32 kept", 46'hD000_0040, 3'd3, 3'd0, 46'hD000_0040);

    // config B: R7 illegal windows
    do_reset();
    load(46'hC000_0000, 46'h1_0000_0000, 46'h1_0000_0000, 46'h1000_0000,
         46'h40_0800_0000, 46'h1000_0000);
    wr(3'd6, 46'd1);
    chk("R7 cfg_err set", 64'(cfg_err_o), 64'd1);
    chk("R8 ovl clear with disabled windows", 64'(ovl_err_o), 64'd0);
    probe("R7 R5 m32 above 4G disabled", 46'h1_0000_0000, 3'd1, 3'd0, 46'hC000_0000);
    probe("R7 m64 misaligned disabled", 46'h40_0800_0000, 3'd0, 3'd0, 46'h0);
    probe("R2 hole with 4G installed", 46'hC000_0000, 3'd0, 3'd0, 46'h0);
    chk("R7 cfg_err sticky", 64'(cfg_err_o), 64'd1);

    // config B2: non power-of-two size
    do_reset();
    load(46'h8000_0000, 46'h8000_0000, 46'hC000_0000, 46'h0300_0000, 46'h0, 46'h0);
    wr(3'd6, 46'd1);
    chk("R7 non pow2 flag", 64'(cfg_err_o), 64'd1);
    probe("R7 non pow2 disabled", 46'hC000_0000, 3'd0, 3'd0, 46'h0);

    // config C: R8 overlaps, R12 priority
    do_reset();
    load(46'hC000_0000, 46'h2_0000_0000, 46'hE000_0000, 46'h1000_0000,
         46'h1_0000_0000, 46'h1000_0000);
    wr(3'd6, 46'd1);
    chk("R8 ovl_err set", 64'(ovl_err_o), 64'd1);
    chk("R7 no cfg_err in C", 64'(cfg_err_o), 64'd0);
    probe("R12 R4 fixed over m32", 46'hE000_0000, 3'd2, 3'd0, 46'hE000_0000);
    probe("R12 m64 over reclaim", 46'h1_0000_0000, 3'd4, 3'd0, 46'h1_0000_0000);
    probe("R3 reclaim after m64", 46'h1_1000_0000, 3'd1, 3'd0, 46'hD000_0000);
    chk("R8 ovl_err sticky", 64'(ovl_err_o), 64'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule